// File: doc/BRIEF.md
# Four-Bit Parallel ALU

A purely combinational arithmetic and logic unit for a narrow CPU datapath. It takes two 4-bit two's-complement operands and a 3-bit operation code and produces a single 4-bit result. Addition, subtraction, bitwise AND, bitwise OR, inversion of the first operand and a logical left shift are all computed side by side. A one-hot select from the control decoder then picks the answer.

Addition uses a carry-lookahead adder. Every carry is a two-level sum of products over per-bit generate and propagate terms, so no carry ripples from bit to bit. Subtraction reuses the same adder. Opcode bit 0 inverts B and supplies the carry-in, which yields A + ~B + 1. An ADD-immediate instruction uses the ADD code with the immediate on B. The shift amount is decoded to one-hot and feeds a barrel shifter. The arithmetic results wrap modulo 16, and the block has no flag outputs.

Top module: `alu4`

## Requirements
- R1: Code 3'b000 (add) gives result = (A + B) mod 16.
- R2: Code 3'b001 (subtract) gives result = (A - B) mod 16, formed as A + ~B + 1.
- R3: Code 3'b010 gives the bitwise AND of A and B.
- R4: Code 3'b011 gives the bitwise OR of A and B.
- R5: Code 3'b100 gives the bitwise inverse of A, and B has no effect on the result.
- R6: Code 3'b101 gives A shifted left by B[1:0] places with zeros in the vacated low bits, and B[3:2] has no effect on the result.
- R7: Codes 3'b110 and 3'b111 give a result of zero for every operand pair.
- R8: Arithmetic wraps with no carry or overflow output. For example, 4'hF + 4'h1 gives 4'h0, 4'h0 - 4'h1 gives 4'hF, and 4'h7 + 4'h1 gives 4'h8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand; the only operand for invert and shift |
| opB | input | 4 | Second operand; bits [1:0] give the shift amount for the shift code |
| opCode | input | 3 | Operation select |
| result | output | 4 | Selected operation result |

## Verification
Every operand pair is checked under all eight codes, followed by random vectors from a fixed seed. This covers the carry chains that run through all four bits, such as 4'hF + 4'h1 and 4'h0 - 4'h1. A lookahead term that dropped a propagate product would give a wrong value only when the carry crosses several bits. Directed cases vary only B[3:2] under the shift code and only B under the invert code. A decoder that read the wrong bits would change the output when it should not. The two spare codes are checked with all-ones operands, so a mux that let any result through on those codes would show a nonzero value.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int OpBits = 3;

  typedef enum logic [OpBits-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_NOT = 3'b100,
    OP_SHL = 3'b101
  } aluOp_e;

  localparam int NumSel = 5;
  localparam int SelSum = 0;
  localparam int SelAnd = 1;
  localparam int SelOr  = 2;
  localparam int SelNot = 3;
  localparam int SelShl = 4;

  typedef struct packed {
    logic              invertB;
    logic              carryIn;
    logic [NumSel-1:0] pick;
  } aluStrobe_t;
endpackage

// File: rtl/alu4_cla.sv
module alu4_cla #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH:0]   carry;

  assign gen  = addA & addB;
  assign prop = addA | addB;

  // Each carry is a flat OR of products: g[j] & p[j+1..i-1], plus cin & p[0..i-1].
  always_comb begin
    carry = '0;
    carry[0] = cin;
    for (int i = 1; i <= WIDTH; i++) begin
      logic term;
      term = cin;
      for (int k = 0; k < i; k++) term = term & prop[k];
      carry[i] = term;
      for (int j = 0; j < i; j++) begin
        logic t;
        t = gen[j];
        for (int k = j + 1; k < i; k++) t = t & prop[k];
        carry[i] = carry[i] | t;
      end
    end
  end

  assign sum = addA ^ addB ^ carry[WIDTH-1:0];

  // R1 R2 R8: lookahead sum agrees with modular arithmetic
  always_comb begin
    assert_cla_sum_R8: assert (sum == WIDTH'(addA + addB + {{(WIDTH-1){1'b0}}, cin}));
  end
endmodule

// File: rtl/alu4_shl.sv
module alu4_shl #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]         shIn,
  input  logic [$clog2(WIDTH)-1:0] shAmt,
  output logic [WIDTH-1:0]         shOut
);
  localparam int Taps = WIDTH;

  logic [Taps-1:0] decSel;
  logic [WIDTH-1:0] tapVal [Taps];

  always_comb begin
    decSel = '0;
    decSel[shAmt] = 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < Taps; k++) begin : g_tap
      assign tapVal[k] = decSel[k] ? (shIn << k) : '0;
    end
  endgenerate

  always_comb begin
    shOut = '0;
    for (int k2 = 0; k2 < Taps; k2++) shOut = shOut | tapVal[k2];
  end

  // R6: exactly one barrel tap active
  always_comb begin
    assert_shl_onehot_R6: assert ($countones(decSel) == 1);
  end
endmodule

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [OpBits-1:0] opCode,
  output aluStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    strobe.invertB = opCode[0];
    strobe.carryIn = opCode[0];
    case (opCode)
      OP_ADD, OP_SUB: strobe.pick[SelSum] = 1'b1;
      OP_AND:         strobe.pick[SelAnd] = 1'b1;
      OP_OR:          strobe.pick[SelOr]  = 1'b1;
      OP_NOT:         strobe.pick[SelNot] = 1'b1;
      OP_SHL:         strobe.pick[SelShl] = 1'b1;
      default:        strobe.pick = '0;
    endcase
  end

  // R7: spare codes select nothing; others select one result
  always_comb begin
    assert_ctrl_pick_R7: assert ($onehot0(strobe.pick) &&
                                 ((opCode[2:1] == 2'b11) == (strobe.pick == '0)));
  end
endmodule

// File: rtl/alu4_dp.sv
module alu4_dp
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result
);
  localparam int ShBits = $clog2(WIDTH);

  logic [WIDTH-1:0] invA, invB, bSel;
  logic [WIDTH-1:0] sumRes, andRes, orRes, notRes, shlRes;

  assign invA = ~opA;
  assign invB = ~opB;
  assign bSel = strobe.invertB ? invB : opB;

  alu4_cla #(.WIDTH(WIDTH)) u_cla (
    .addA(opA), .addB(bSel), .cin(strobe.carryIn), .sum(sumRes)
  );

  alu4_shl #(.WIDTH(WIDTH)) u_shl (
    .shIn(opA), .shAmt(opB[ShBits-1:0]), .shOut(shlRes)
  );

  assign andRes = ~(invA | invB);
  assign orRes  = ~(invA & invB);
  assign notRes = invA;

  always_comb begin
    result = '0;
    if (strobe.pick[SelSum]) result = result | sumRes;
    if (strobe.pick[SelAnd]) result = result | andRes;
    if (strobe.pick[SelOr])  result = result | orRes;
    if (strobe.pick[SelNot]) result = result | notRes;
    if (strobe.pick[SelShl]) result = result | shlRes;
  end

  // R3 R4: inverted-operand gates match plain AND/OR
  always_comb begin
    assert_logic_R3: assert (andRes == (opA & opB));
    assert_logic_R4: assert (orRes == (opA | opB));
    assert_empty_pick_R7: assert ((strobe.pick != '0) || (result == '0));
  end
endmodule

// File: rtl/alu4.sv
module alu4
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [OpBits-1:0] opCode,
  output logic [WIDTH-1:0]  result
);
  aluStrobe_t strobe;

  alu4_ctrl u_ctrl (.opCode(opCode), .strobe(strobe));

  alu4_dp #(.WIDTH(WIDTH)) u_dp (
    .opA(opA), .opB(opB), .strobe(strobe), .result(result)
  );
endmodule

// File: tb/alu4_bench.sv
module alu4_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] opA, opB, result;
  logic [2:0] opCode;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  alu4 u_alu4 (.opA(opA), .opB(opB), .opCode(opCode), .result(result));

  function automatic logic [3:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic [2:0] op);
    int s;
    case (op)
      3'd0: begin s = a + b; return s[3:0]; end
      3'd1: begin s = a - b + 16; return s[3:0]; end
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return ~a;
      3'd5: return a << b[1:0];
      default: return 4'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op,
                       input logic [3:0] exp, input string tag);
    @(posedge clk);
    opA = a; opB = b; opCode = op;
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h op=%0d actual=%h expected=%h", tag, a, b, op, result, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] a, b;
    logic [2:0] op;
    opA = '0; opB = '0; opCode = '0;
    // R1 reset-quiescent state: zero operands under add give zero
    apply(4'h0, 4'h0, 3'd0, 4'h0, "R1");
    // R8 wrap corners
    apply(4'hF, 4'h1, 3'd0, 4'h0, "R8");
    apply(4'h0, 4'h1, 3'd1, 4'hF, "R8");
    apply(4'h7, 4'h1, 3'd0, 4'h8, "R8");
    apply(4'h8, 4'h1, 3'd1, 4'h7, "R8");
    // R6 upper shift bits ignored
    apply(4'hB, 4'h1, 3'd5, 4'h6, "R6");
    apply(4'hB, 4'hD, 3'd5, 4'h6, "R6");
    apply(4'hB, 4'h3, 3'd5, 4'h8, "R6");
    // R5 B ignored
    apply(4'h5, 4'h0, 3'd4, 4'hA, "R5");
    apply(4'h5, 4'hF, 3'd4, 4'hA, "R5");
    // R7 spare codes with all ones
    apply(4'hF, 4'hF, 3'd6, 4'h0, "R7");
    apply(4'hF, 4'hF, 3'd7, 4'h0, "R7");
    // exhaustive sweep, all requirements R1..R7 by code
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(4'(i), 4'(j), 3'(o), model(4'(i), 4'(j), 3'(o)), tagOf(3'(o)));
    // constrained random, fixed seed
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      a = 4'($urandom);
      b = 4'($urandom);
      op = 3'($urandom_range(0, 5));
      apply(a, b, op, model(a, b, op), tagOf(op));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule